// File: doc/BRIEF.md
# Write Leveling Phase Search

This controller finds, for each byte lane of a DRAM interface, the output delay setting at which the write strobe's rising edge lines up with the memory clock at the device. While the DRAM is in write-leveling mode, it latches the memory clock on every strobe rising edge and drives the captured level back on its data lines. The controller steps the strobe output delay upward from zero. At each step it asks for a fixed number of strobe toggles and collects the feedback bit returned with each one. It reduces those samples to one level by majority vote.

A lane locks at the first step whose voted level is 1 when the step before it voted 0. That delay is stored in the lane's result register. If the lane is already high at the start, the sweep runs on until it has seen a low level followed by a high one. A lane that reaches the top delay setting without such a rise is marked as failed. Lanes are processed one after another in ascending order. The delay cells, the toggling hardware and the mode-register sequencing sit outside the block and are reached through two request/acknowledge pairs.

Top module: `wl_phase_search`

## Requirements
- R1: After reset, busy_o, done_o, dly_req_o and tgl_req_o are 0, and every result field and fail bit is 0.
- R2: Each step raises dly_req_o once with the step's delay on dly_val_o. dly_req_o is held until dly_ack_i. Then tgl_req_o stays high until exactly VOTES (4) toggle acknowledges have been taken, and the two requests are never high together.
- R3: For each lane the delay starts at 0 and rises by exactly 1 per step. It holds steady while toggles are requested.
- R4: A step votes 1 only when at least 3 of its 4 feedback samples (fb_i, taken in cycles where tgl_ack_i is high) are 1. A 2-of-4 tie votes 0. A single wrong sample therefore cannot change the vote.
- R5: A lane's result is the delay of the first step voting 1 right after a step voting 0. That lane's sweep stops at this step.
- R6: Steps that vote 1 before any step of the lane has voted 0 never lock the lane.
- R7: If the step at the maximum delay (2**DLY_W-1) ends without a lock, the lane's fail bit is set to 1 and its result field is 0. A locked lane has fail bit 0.
- R8: Lanes are swept in order 0 to NUM_LANES-1, shown on dly_lane_o. Lane n's result lives in res_dly_o[n*DLY_W +: DLY_W] and its fail bit in res_fail_o[n].
- R9: busy_o rises in the cycle after start_i is taken. After the last lane, done_o is high for exactly one cycle, and busy_o is 0 from the next cycle on. While idle, no request is raised.
- R10: start_i is ignored while busy_o is high. The run continues unchanged and produces a single done_o pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin a sweep over all lanes |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle pulse at the end of the sweep |
| dly_lane_o | output | LANE_W | Lane whose strobe delay is being driven |
| dly_val_o | output | DLY_W | Strobe output delay setting for that lane |
| dly_req_o | output | 1 | Request to apply dly_val_o |
| dly_ack_i | input | 1 | Delay applied |
| tgl_req_o | output | 1 | Request strobe toggles |
| tgl_ack_i | input | 1 | One toggle done, fb_i valid in this cycle |
| fb_i | input | 1 | Clock level captured by the DRAM and returned on data lines |
| res_dly_o | output | NUM_LANES*DLY_W | Locked delay for each lane |
| res_fail_o | output | NUM_LANES | Per-lane no-rise flag |

## Verification
A vote counter that is stuck or off by one shows up as a result one or more steps away from the true rising edge. It can also show as a lock on a lone noisy sample, and it is visible in the result register once done_o pulses. A lost or inverted previous-step flag either locks a lane that starts high at delay 0 or skips the true edge, which again shows in the stored result. Wrong step sequencing appears immediately on dly_val_o, or as a toggle count other than four within the very next step. A lane counter fault puts results in the wrong field or gives an extra or missing done_o pulse at the end of the run.

// File: rtl/wl_phase_pkg.sv
package wl_phase_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SET,
    ST_TGL,
    ST_EVAL,
    ST_NEXT,
    ST_DONE
  } wl_state_e;
endpackage

// File: rtl/wl_vote_acc.sv
module wl_vote_acc #(
  parameter int VOTES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic smp_en_i,
  input  logic smp_bit_i,
  output logic last_o,
  output logic vote_o
);
  localparam int CNT_W = $clog2(VOTES + 1);
  localparam int THR   = VOTES / 2 + 1;

  logic [CNT_W-1:0] rep_q, rep_d;
  logic [CNT_W-1:0] ones_q, ones_d;

  always_comb begin
    rep_d  = rep_q;
    ones_d = ones_q;
    if (clr_i) begin
      rep_d  = '0;
      ones_d = '0;
    end else if (smp_en_i) begin
      rep_d  = rep_q + CNT_W'(1);
      ones_d = ones_q + CNT_W'(smp_bit_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rep_q  <= '0;
      ones_q <= '0;
    end else if (clr_i || smp_en_i) begin
      rep_q  <= rep_d;
      ones_q <= ones_d;
    end
  end

  assign last_o = (rep_q == CNT_W'(VOTES - 1));
  assign vote_o = (ones_q >= CNT_W'(THR));
endmodule

// File: rtl/wl_rise_track.sv
module wl_rise_track (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic upd_en_i,
  input  logic vote_i,
  output logic lock_o
);
  logic low_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_seen_q <= 1'b0;
    end else if (arm_i) begin
      low_seen_q <= 1'b0;
    end else if (upd_en_i) begin
      low_seen_q <= ~vote_i;
    end
  end

  assign lock_o = low_seen_q & vote_i;
endmodule

// File: rtl/wl_result_bank.sv
module wl_result_bank #(
  parameter int NUM_LANES = 2,
  parameter int DLY_W     = 5,
  parameter int LANE_W    = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en_i,
  input  logic [LANE_W-1:0]          wr_lane_i,
  input  logic [DLY_W-1:0]           wr_dly_i,
  input  logic                       wr_fail_i,
  output logic [NUM_LANES*DLY_W-1:0] res_dly_o,
  output logic [NUM_LANES-1:0]       res_fail_o
);
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic             hit;
    logic [DLY_W-1:0] dly_q;
    logic             fail_q;

    assign hit = wr_en_i && (wr_lane_i == LANE_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dly_q  <= '0;
        fail_q <= 1'b0;
      end else if (hit) begin
        dly_q  <= wr_dly_i;
        fail_q <= wr_fail_i;
      end
    end

    assign res_dly_o[g*DLY_W +: DLY_W] = dly_q;
    assign res_fail_o[g]               = fail_q;
  end
endmodule

// File: rtl/wl_phase_search.sv
module wl_phase_search #(
  parameter int NUM_LANES = 2,
  parameter int DLY_W     = 5,
  parameter int VOTES     = 4,
  parameter int LANE_W    = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic [LANE_W-1:0]          dly_lane_o,
  output logic [DLY_W-1:0]           dly_val_o,
  output logic                       dly_req_o,
  input  logic                       dly_ack_i,
  output logic                       tgl_req_o,
  input  logic                       tgl_ack_i,
  input  logic                       fb_i,
  output logic [NUM_LANES*DLY_W-1:0] res_dly_o,
  output logic [NUM_LANES-1:0]       res_fail_o
);
  import wl_phase_pkg::*;

  localparam logic [DLY_W-1:0]  DLY_MAX   = {DLY_W{1'b1}};
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(NUM_LANES - 1);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  wl_state_e         state_q, state_d;
  logic [LANE_W-1:0] lane_q, lane_d;
  logic [DLY_W-1:0]  dly_q, dly_d;

  logic vote_clr, vote_smp, vote_last, vote;
  logic arm, upd_en, lock;
  logic wr_en, wr_fail;
  logic [DLY_W-1:0] wr_dly;

  always_comb begin
    state_d  = state_q;
    lane_d   = lane_q;
    dly_d    = dly_q;
    vote_clr = 1'b0;
    vote_smp = 1'b0;
    arm      = 1'b0;
    upd_en   = 1'b0;
    wr_en    = 1'b0;
    wr_fail  = 1'b0;
    wr_dly   = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          lane_d  = '0;
          dly_d   = '0;
          arm     = 1'b1;
          state_d = ST_SET;
        end
      end
      ST_SET: begin
        if (dly_ack_i) begin
          vote_clr = 1'b1;
          state_d  = ST_TGL;
        end
      end
      ST_TGL: begin
        if (tgl_ack_i) begin
          vote_smp = 1'b1;
          if (vote_last) state_d = ST_EVAL;
        end
      end
      ST_EVAL: begin
        upd_en = 1'b1;
        if (lock) begin
          wr_en   = 1'b1;
          wr_dly  = dly_q;
          state_d = ST_NEXT;
        end else if (dly_q == DLY_MAX) begin
          wr_en   = 1'b1;
          wr_fail = 1'b1;
          state_d = ST_NEXT;
        end else begin
          dly_d   = dly_q + DLY_W'(1);
          state_d = ST_SET;
        end
      end
      ST_NEXT: begin
        if (lane_q == LAST_LANE) begin
          state_d = ST_DONE;
        end else begin
          lane_d  = lane_q + LANE_W'(1);
          dly_d   = '0;
          arm     = 1'b1;
          state_d = ST_SET;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      lane_q  <= '0;
      dly_q   <= '0;
    end else begin
      state_q <= state_d;
      lane_q  <= lane_d;
      dly_q   <= dly_d;
    end
  end

  wl_vote_acc #(.VOTES(VOTES)) u_vote (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clr_i     (vote_clr),
    .smp_en_i  (vote_smp),
    .smp_bit_i (fb_i),
    .last_o    (vote_last),
    .vote_o    (vote)
  );

  wl_rise_track u_rise (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .arm_i    (arm),
    .upd_en_i (upd_en),
    .vote_i   (vote),
    .lock_o   (lock)
  );

  wl_result_bank #(
    .NUM_LANES (NUM_LANES),
    .DLY_W     (DLY_W),
    .LANE_W    (LANE_W)
  ) u_bank (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en_i    (wr_en),
    .wr_lane_i  (lane_q),
    .wr_dly_i   (wr_dly),
    .wr_fail_i  (wr_fail),
    .res_dly_o  (res_dly_o),
    .res_fail_o (res_fail_o)
  );

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_DONE);
  assign dly_req_o  = (state_q == ST_SET);
  assign tgl_req_o  = (state_q == ST_TGL);
  assign dly_lane_o = lane_q;
  assign dly_val_o  = dly_q;
endmodule

// File: rtl/wl_phase_search_chk.sv
module wl_phase_search_chk #(
  parameter int DLY_W  = 5,
  parameter int VOTES  = 4,
  parameter int LANE_W = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              done_o,
  input logic [LANE_W-1:0] dly_lane_o,
  input logic [DLY_W-1:0]  dly_val_o,
  input logic              dly_req_o,
  input logic              dly_ack_i,
  input logic              tgl_req_o,
  input logic              tgl_ack_i
);
  localparam int CW = $clog2(VOTES + 2);

  logic [CW-1:0]    tog_cnt;
  logic [DLY_W-1:0] last_dly;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_cnt  <= '0;
      last_dly <= '0;
    end else if (dly_req_o && dly_ack_i) begin
      tog_cnt  <= '0;
      last_dly <= dly_val_o;
    end else if (tgl_req_o && tgl_ack_i) begin
      tog_cnt  <= tog_cnt + CW'(1);
    end
  end

  // R2
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dly_req_o && tgl_req_o));

  // R2
  tgl_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tgl_req_o && tgl_ack_i) |-> (tog_cnt < CW'(VOTES)));

  // R2
  step_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dly_req_o) && tog_cnt != '0) |-> (tog_cnt == CW'(VOTES)));

  // R3
  dly_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgl_req_o |-> $stable(dly_val_o));

  // R3
  step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dly_req_o) && dly_val_o != '0) |-> (dly_val_o == last_dly + DLY_W'(1)));

  // R8
  lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgl_req_o |-> $stable(dly_lane_o));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!dly_req_o && !tgl_req_o));
endmodule

bind wl_phase_search wl_phase_search_chk #(
  .DLY_W  (DLY_W),
  .VOTES  (VOTES),
  .LANE_W (LANE_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .dly_lane_o (dly_lane_o),
  .dly_val_o  (dly_val_o),
  .dly_req_o  (dly_req_o),
  .dly_ack_i  (dly_ack_i),
  .tgl_req_o  (tgl_req_o),
  .tgl_ack_i  (tgl_ack_i)
);

// File: tb/wl_phase_search_bench.sv
module wl_phase_search_bench;
  localparam int NL = 2;
  localparam int DW = 5;
  localparam int LW = 1;

  logic clk, rst_n, start_i;
  logic busy_o, done_o, dly_req_o, dly_ack_i, tgl_req_o, tgl_ack_i, fb_i;
  logic [LW-1:0]    dly_lane_o;
  logic [DW-1:0]    dly_val_o;
  logic [NL*DW-1:0] res_dly_o;
  logic [NL-1:0]    res_fail_o;

  wl_phase_search #(.NUM_LANES(NL), .DLY_W(DW), .VOTES(4)) u_wl_phase_search (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
    .dly_lane_o(dly_lane_o), .dly_val_o(dly_val_o), .dly_req_o(dly_req_o),
    .dly_ack_i(dly_ack_i), .tgl_req_o(tgl_req_o), .tgl_ack_i(tgl_ack_i),
    .fb_i(fb_i), .res_dly_o(res_dly_o), .res_fail_o(res_fail_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int errs = 0, checks = 0, cyc = 0;

  // DRAM feedback model parameters
  int edge_at[NL];
  int hi_until, noise_d, tie_d;

  // protocol monitor state
  int tog_cnt, last_lane, last_dly, proto_err, seq_err, done_cnt;
  bit step_open;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic fb_model(input int lane, input int d, input int k);
    logic b;
    b = (d < hi_until) ? 1'b1 : (d >= edge_at[lane]);
    if (d == noise_d && k == 0) b = ~b;
    if (d == tie_d) b = (k < 2);
    return b;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errs++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  // responder and protocol monitor, active away from the rising edge
  always @(negedge clk) begin
    dly_ack_i = dly_req_o;
    tgl_ack_i = tgl_req_o;
    fb_i      = 1'b0;
    if (done_o) done_cnt++;
    if (dly_req_o) begin
      if (step_open && tog_cnt != 4) proto_err++;                     // R2
      if (int'(dly_lane_o) == last_lane) begin
        if (int'(dly_val_o) != last_dly + 1) seq_err++;               // R3
      end else begin
        if (int'(dly_val_o) != 0 || int'(dly_lane_o) != last_lane + 1) seq_err++; // R3 R8
      end
      last_lane = int'(dly_lane_o);
      last_dly  = int'(dly_val_o);
      tog_cnt   = 0;
      step_open = 1'b1;
    end
    if (tgl_req_o) begin
      fb_i = fb_model(int'(dly_lane_o), int'(dly_val_o), tog_cnt);
      tog_cnt++;
    end
    if (dly_req_o && tgl_req_o) proto_err++;                          // R2
  end

  task automatic run_case(input string name, input int e0, input int e1, input int hu,
                          input int nd, input int td, input int x0, input int x1,
                          input int f0, input int f1, input bit poke);
    int n;
    edge_at[0] = e0; edge_at[1] = e1;
    hu = hu; hi_until = hu; noise_d = nd; tie_d = td;
    @(negedge clk);
    tog_cnt = 0; last_lane = -1; last_dly = 0; proto_err = 0; seq_err = 0;
    done_cnt = 0; step_open = 1'b0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R9", {name, " busy after start"}, int'(busy_o), 1);
    n = 0;
    while (!done_o && n < 5000) begin
      @(negedge clk);
      n++;
      if (poke && n == 10) start_i = 1'b1;                            // R10
      if (poke && n == 11) start_i = 1'b0;
    end
    chk("R9", {name, " done seen"}, int'(done_o), 1);
    chk("R2", {name, " last step toggles"}, tog_cnt, 4);
    chk("R5", {name, " lane0 result"}, int'(res_dly_o[0 +: DW]), x0);
    chk("R8", {name, " lane1 result"}, int'(res_dly_o[DW +: DW]), x1);
    chk("R7", {name, " lane0 fail"}, int'(res_fail_o[0]), f0);
    chk("R7", {name, " lane1 fail"}, int'(res_fail_o[1]), f1);
    repeat (3) @(negedge clk);
    chk("R9", {name, " idle after done"}, int'(busy_o), 0);
    chk("R9", {name, " single done pulse"}, done_cnt, 1);
    chk("R2", {name, " step protocol"}, proto_err, 0);
    chk("R3", {name, " delay sequence"}, seq_err, 0);
    chk("R8", {name, " lane count"}, last_lane, NL - 1);
  endtask

  task automatic t_reset();
    chk("R1", "busy", int'(busy_o), 0);
    chk("R1", "done", int'(done_o), 0);
    chk("R1", "requests", int'(dly_req_o) + int'(tgl_req_o), 0);
    chk("R1", "results", int'(res_dly_o), 0);
    chk("R1", "fails", int'(res_fail_o), 0);
  endtask

  task automatic t_basic();       run_case("basic",   5,  9, 0, -1, -1,  5,  9, 0, 0, 1'b0); endtask // R5
  task automatic t_start_high();  run_case("high",    7,  2, 3, -1, -1,  7,  0, 0, 1, 1'b0); endtask // R6 R7
  task automatic t_noise();       run_case("noise",   4, 12, 0,  4, -1,  4, 12, 0, 0, 1'b0); endtask // R4
  task automatic t_tie();         run_case("tie",     6,  6, 0, -1,  6,  7,  7, 0, 0, 1'b0); endtask // R4
  task automatic t_edges();       run_case("edges",   1, 31, 0, -1, -1,  1, 31, 0, 0, 1'b0); endtask // R5 R7
  task automatic t_no_rise();     run_case("norise", 40,  0, 0, -1, -1,  0,  0, 1, 1, 1'b0); endtask // R7 R6
  task automatic t_poke();        run_case("poke",   10,  3, 0, -1, -1, 10,  3, 0, 0, 1'b1); endtask // R10

  initial begin
    rst_n = 1'b0; start_i = 1'b0; dly_ack_i = 1'b0; tgl_ack_i = 1'b0; fb_i = 1'b0;
    hi_until = 0; noise_d = -1; tie_d = -1; edge_at[0] = 0; edge_at[1] = 0;
    tog_cnt = 0; last_lane = -1; last_dly = 0; proto_err = 0; seq_err = 0;
    done_cnt = 0; step_open = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_start_high();
    t_noise();
    t_tie();
    t_edges();
    t_no_rise();
    t_poke();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule